// File: doc/BRIEF.md
# Supervisor-Controlled Peripheral Access Firewall

This block sits between two bus ports and the slave decode of a chip that has two masters domains. One port belongs to a trusted monitor processor. The other port is shared by the main-domain masters, a main CPU and a DMA engine, told apart by a master-ID input. For each request the firewall decides, at the moment it accepts the request, whether to forward it onto a single shared slave channel or to answer it locally with an error. A blocked request never hangs. It gets an error response after a fixed number of cycles.

The monitor owns a small control page. It can lock each peripheral on its own, and it is the only master that can release a lock. A set of address windows in external memory is reserved for the monitor at all times. The monitor keeps full access to every slave, including locked ones, so it can drive those interfaces itself. The main-domain masters can never change the control state.

Top module: `periph_firewall`

## Requirements
- R1: Every access from the main port to the control page (address bits [15:12] = 0xF) gets an error response and leaves the lock bits unchanged. Only monitor writes can change them.
- R2: After reset all lock bits are clear. A monitor write to control offset 0x0 sets each lock bit whose write-data bit is 1. A monitor read of the control page returns the lock bits in data bits [NPERIPH-1:0], with zero above them. Monitor control accesses respond without error one cycle after acceptance.
- R3: A monitor write to control offset 0x4 clears each lock bit whose write-data bit is 1. Lock bits whose write-data bit is 0 stay as they were.
- R4: Peripheral k sits on page k (address bits [15:12] = k, k < NPERIPH). While lock bit k is set, a main-port request to page k is not put on the slave channel and gets an error response.
- R5: An error response arrives exactly ERR_LAT cycles after the request is accepted. It lasts one cycle, with the error flag set and zero read data.
- R6: Monitor requests to a locked peripheral are forwarded and complete normally. Read data comes back from the slave.
- R7: Main-port requests that fall inside a protected window (default 0x8000–0x87FF and 0xA000–0xAFFF) are always rejected with an error response. Monitor requests to the same addresses are forwarded. Memory outside the windows on pages 0x8–0xB stays open to the main port.
- R8: The decision to allow or block is made when the request is accepted. A main-port transfer accepted in the same cycle as a lock write, or before it, completes normally. Only later requests see the lock.
- R9: Unlocked main-port requests are forwarded with their address, direction and data. The slave select is one-hot: bit k for page k, bit NPERIPH for memory pages. The master tag reads 0 for the monitor, 1 for the main CPU and 2 for DMA. The read data is returned without error. The channel holds a request steady until the slave accepts it.
- R10: A request to a page that maps to no peripheral, no memory and no control page gets an error response on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Monitor request valid |
| m_ready | output | 1 | Monitor port can accept |
| m_addr | input | AW | Monitor request address |
| m_write | input | 1 | Monitor request is a write |
| m_wdata | input | DW | Monitor write data |
| m_rsp_valid | output | 1 | Monitor response pulse |
| m_rsp_err | output | 1 | Monitor response is an error |
| m_rsp_rdata | output | DW | Monitor read data |
| h_valid | input | 1 | Main-domain request valid |
| h_ready | output | 1 | Main port can accept |
| h_addr | input | AW | Main-domain request address |
| h_write | input | 1 | Main-domain request is a write |
| h_wdata | input | DW | Main-domain write data |
| h_dma | input | 1 | Main-domain request comes from DMA (else from main CPU) |
| h_rsp_valid | output | 1 | Main-domain response pulse |
| h_rsp_err | output | 1 | Main-domain response is an error |
| h_rsp_rdata | output | DW | Main-domain read data |
| s_valid | output | 1 | Slave channel request valid |
| s_ready | input | 1 | Slave accepts the request |
| s_addr | output | AW | Slave request address |
| s_write | output | 1 | Slave request is a write |
| s_wdata | output | DW | Slave write data |
| s_sel | output | NPERIPH+1 | One-hot slave select, top bit is memory |
| s_mid | output | 2 | Originating master tag |
| s_rsp_valid | input | 1 | Slave response valid |
| s_rdata | input | DW | Slave read data |

## Verification
Latency is counted from the cycle in which a request is accepted. A control-page access is due one cycle later, and a blocked or unmapped access exactly ERR_LAT cycles later. A forwarded access is due once the slave answers. The bench counts cycles from the accepting edge and samples each response on the falling edge, so an early or late error response shows up as a latency mismatch and not as a missed pulse. For the in-flight case, the lock write and the main-domain request are issued in the same cycle. The bench then checks that this transfer still reaches the slave, and that the next request to the same page is stopped.

// File: rtl/periph_firewall.sv
module periph_firewall #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NPERIPH = 4,
  parameter int ERR_LAT = 4,
  parameter int NWIN = 2,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'hA000, 16'h8000},
  parameter logic [NWIN*AW-1:0] WIN_MASK = {16'hF000, 16'hF800},
  parameter int MEM_PG_LO = 8,
  parameter int MEM_PG_HI = 11,
  parameter int CTRL_PG = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_valid,
  output logic             m_ready,
  input  logic [AW-1:0]    m_addr,
  input  logic             m_write,
  input  logic [DW-1:0]    m_wdata,
  output logic             m_rsp_valid,
  output logic             m_rsp_err,
  output logic [DW-1:0]    m_rsp_rdata,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic [AW-1:0]    h_addr,
  input  logic             h_write,
  input  logic [DW-1:0]    h_wdata,
  input  logic             h_dma,
  output logic             h_rsp_valid,
  output logic             h_rsp_err,
  output logic [DW-1:0]    h_rsp_rdata,
  output logic             s_valid,
  input  logic             s_ready,
  output logic [AW-1:0]    s_addr,
  output logic             s_write,
  output logic [DW-1:0]    s_wdata,
  output logic [NPERIPH:0] s_sel,
  output logic [1:0]       s_mid,
  input  logic             s_rsp_valid,
  input  logic [DW-1:0]    s_rdata
);

  localparam int PGW = 4;
  localparam int SW  = NPERIPH + 1;
  localparam int CW  = (ERR_LAT > 2) ? $clog2(ERR_LAT) : 1;

  typedef enum logic [1:0] {P_IDLE, P_BUS, P_ERR} port_st_t;
  typedef enum logic [1:0] {B_IDLE, B_REQ, B_WAIT} bus_st_t;

  logic [NPERIPH-1:0] lock;

  logic          pv   [2];
  logic [AW-1:0] pa   [2];
  logic          pw   [2];
  logic [DW-1:0] pd   [2];
  logic [1:0]    pmid [2];

  assign pv[0] = m_valid;  assign pv[1] = h_valid;
  assign pa[0] = m_addr;   assign pa[1] = h_addr;
  assign pw[0] = m_write;  assign pw[1] = h_write;
  assign pd[0] = m_wdata;  assign pd[1] = h_wdata;
  assign pmid[0] = 2'd0;
  assign pmid[1] = h_dma ? 2'd2 : 2'd1;

  logic          dec_reg [2];
  logic          dec_err [2];
  logic [SW-1:0] dec_sel [2];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [PGW-1:0]     page;
    logic [NPERIPH-1:0] ph;
    logic [NWIN-1:0]    wh;
    logic               is_ctrl, is_mem;

    assign page    = pa[p][AW-1 -: PGW];
    assign is_ctrl = (page == PGW'(CTRL_PG));
    assign is_mem  = (page >= PGW'(MEM_PG_LO)) && (page <= PGW'(MEM_PG_HI));

    for (genvar i = 0; i < NPERIPH; i++) begin : g_ph
      assign ph[i] = (page == PGW'(i));
    end
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign wh[w] = (pa[p] & WIN_MASK[w*AW +: AW]) == WIN_BASE[w*AW +: AW];
    end

    if (p == 0) begin : g_mon
      assign dec_reg[p] = is_ctrl;
      assign dec_err[p] = !is_ctrl && !is_mem && (ph == '0);
    end else begin : g_main
      assign dec_reg[p] = 1'b0;
      assign dec_err[p] = is_ctrl || (!is_mem && (ph == '0)) ||
                          (|wh) || (|(ph & lock));
    end
    assign dec_sel[p] = {is_mem, ph};
  end

  port_st_t      st    [2];
  logic [CW-1:0] cnt   [2];
  logic [AW-1:0] ra    [2];
  logic          rw    [2];
  logic [DW-1:0] rd    [2];
  logic [SW-1:0] rsel  [2];
  logic [1:0]    rmid  [2];
  logic          rsp_v [2];
  logic          rsp_e [2];
  logic [DW-1:0] rsp_d [2];

  bus_st_t bus_st;
  logic    bus_own;
  logic    acc [2];

  assign acc[0] = pv[0] && (st[0] == P_IDLE);
  assign acc[1] = pv[1] && (st[1] == P_IDLE);

  wire grant_m = (bus_st == B_IDLE) && (st[0] == P_BUS);
  wire grant_h = (bus_st == B_IDLE) && (st[1] == P_BUS) && !grant_m;
  wire bus_done = (bus_st == B_WAIT) && s_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_st  <= B_IDLE;
      bus_own <= 1'b0;
    end else begin
      case (bus_st)
        B_IDLE: begin
          if (grant_m) begin
            bus_own <= 1'b0;
            bus_st  <= B_REQ;
          end else if (grant_h) begin
            bus_own <= 1'b1;
            bus_st  <= B_REQ;
          end
        end
        B_REQ:   if (s_ready) bus_st <= B_WAIT;
        B_WAIT:  if (s_rsp_valid) bus_st <= B_IDLE;
        default: bus_st <= B_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (!rst_n) begin
        st[p]    <= P_IDLE;
        cnt[p]   <= '0;
        ra[p]    <= '0;
        rw[p]    <= 1'b0;
        rd[p]    <= '0;
        rsel[p]  <= '0;
        rmid[p]  <= '0;
        rsp_v[p] <= 1'b0;
        rsp_e[p] <= 1'b0;
        rsp_d[p] <= '0;
      end else begin
        rsp_v[p] <= 1'b0;
        case (st[p])
          P_IDLE: begin
            if (acc[p]) begin
              ra[p]   <= pa[p];
              rw[p]   <= pw[p];
              rd[p]   <= pd[p];
              rsel[p] <= dec_sel[p];
              rmid[p] <= pmid[p];
              if (dec_reg[p]) begin
                rsp_v[p] <= 1'b1;
                rsp_e[p] <= 1'b0;
                rsp_d[p] <= pw[p] ? '0 : DW'(lock);
              end else if (dec_err[p]) begin
                st[p]  <= P_ERR;
                cnt[p] <= CW'(ERR_LAT - 2);
              end else begin
                st[p] <= P_BUS;
              end
            end
          end
          P_BUS: begin
            if (bus_done && (bus_own == (p == 1))) begin
              rsp_v[p] <= 1'b1;
              rsp_e[p] <= 1'b0;
              rsp_d[p] <= s_rdata;
              st[p]    <= P_IDLE;
            end
          end
          P_ERR: begin
            if (cnt[p] == '0) begin
              rsp_v[p] <= 1'b1;
              rsp_e[p] <= 1'b1;
              rsp_d[p] <= '0;
              st[p]    <= P_IDLE;
            end else begin
              cnt[p] <= cnt[p] - 1'b1;
            end
          end
          default: st[p] <= P_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock <= '0;
    end else if (acc[0] && dec_reg[0] && pw[0]) begin
      case (pa[0][3:2])
        2'd0:    lock <= lock | pd[0][NPERIPH-1:0];
        2'd1:    lock <= lock & ~pd[0][NPERIPH-1:0];
        default: lock <= lock;
      endcase
    end
  end

  assign m_ready     = (st[0] == P_IDLE);
  assign h_ready     = (st[1] == P_IDLE);
  assign m_rsp_valid = rsp_v[0];
  assign m_rsp_err   = rsp_e[0];
  assign m_rsp_rdata = rsp_d[0];
  assign h_rsp_valid = rsp_v[1];
  assign h_rsp_err   = rsp_e[1];
  assign h_rsp_rdata = rsp_d[1];

  assign s_valid = (bus_st == B_REQ);
  assign s_addr  = ra[bus_own];
  assign s_write = rw[bus_own];
  assign s_wdata = rd[bus_own];
  assign s_sel   = (bus_st == B_REQ) ? rsel[bus_own] : '0;
  assign s_mid   = rmid[bus_own];

endmodule

// File: rtl/fw_checks.sv
module fw_checks #(
  parameter int AW = 16,
  parameter int NPERIPH = 4,
  parameter int ERR_LAT = 4,
  parameter int NWIN = 2,
  parameter logic [NWIN*AW-1:0] WIN_BASE = {16'hA000, 16'h8000},
  parameter logic [NWIN*AW-1:0] WIN_MASK = {16'hF000, 16'hF800},
  parameter int CTRL_PG = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               m_valid,
  input logic               m_ready,
  input logic [AW-1:0]      m_addr,
  input logic               m_write,
  input logic               h_valid,
  input logic               h_ready,
  input logic [AW-1:0]      h_addr,
  input logic               h_rsp_valid,
  input logic               h_rsp_err,
  input logic               s_valid,
  input logic               s_ready,
  input logic [AW-1:0]      s_addr,
  input logic [NPERIPH:0]   s_sel,
  input logic [1:0]         s_mid,
  input logic [NPERIPH-1:0] lock
);

  function automatic logic in_win(input logic [AW-1:0] a);
    logic hit = 1'b0;
    for (int w = 0; w < NWIN; w++)
      if ((a & WIN_MASK[w*AW +: AW]) == WIN_BASE[w*AW +: AW]) hit = 1'b1;
    return hit;
  endfunction

  wire [3:0] hpg = h_addr[AW-1 -: 4];
  wire mon_ctrl_wr = m_valid && m_ready && m_write && (m_addr[AW-1 -: 4] == 4'(CTRL_PG));
  wire h_acc = h_valid && h_ready;
  wire h_hits_lock = (hpg < 4'(NPERIPH)) && |(lock & (NPERIPH'(1) << hpg));

  logic [7:0] since;
  logic       exp_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since    <= '0;
      exp_lock <= 1'b0;
    end else if (h_acc) begin
      since    <= 8'd1;
      exp_lock <= h_hits_lock;
    end else if (since != 8'd0 && since != 8'hFF) begin
      since <= since + 8'd1;
    end
  end

  a_r1_lock_only_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_ctrl_wr |=> $stable(lock));

  a_r4_locked_gets_error: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && exp_lock) |-> h_rsp_err);

  a_r5_error_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rsp_valid && h_rsp_err) |-> (since == 8'(ERR_LAT)));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid |=> !h_rsp_valid);

  a_r7_window_main_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_mid != 2'd0) |-> !in_win(s_addr));

  a_r9_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> ($countones(s_sel) == 1));

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr) && $stable(s_sel)));

endmodule

bind periph_firewall fw_checks #(
  .AW(AW), .NPERIPH(NPERIPH), .ERR_LAT(ERR_LAT), .NWIN(NWIN),
  .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK), .CTRL_PG(CTRL_PG)
) i_fw_checks (.*);

// File: tb/test_periph_firewall.sv
`timescale 1ns/1ps
module test_periph_firewall;
  localparam int AW = 16, DW = 32, NP = 4, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_valid = 0, m_write = 0, h_valid = 0, h_write = 0, h_dma = 0;
  logic [AW-1:0] m_addr = '0, h_addr = '0;
  logic [DW-1:0] m_wdata = '0, h_wdata = '0;
  logic m_ready, m_rsp_valid, m_rsp_err, h_ready, h_rsp_valid, h_rsp_err;
  logic [DW-1:0] m_rsp_rdata, h_rsp_rdata, s_wdata;
  logic s_valid, s_write;
  logic s_ready = 1'b1, s_rsp_valid = 1'b0;
  logic [DW-1:0] s_rdata = '0;
  logic [AW-1:0] s_addr;
  logic [NP:0] s_sel;
  logic [1:0] s_mid;

  periph_firewall i_periph_firewall (.*);

  int errs = 0, checks = 0;
  int n_fwd = 0;
  logic [1:0] last_mid;
  logic [NP:0] last_sel;
  logic [DW-1:0] mem [0:NP][0:15];

  initial begin
    logic pend = 1'b0;
    logic [DW-1:0] pdat = '0;
    for (int i = 0; i <= NP; i++) for (int j = 0; j < 16; j++) mem[i][j] = '0;
    forever begin
      @(negedge clk);
      s_rsp_valid = 1'b0;
      if (pend) begin
        s_rsp_valid = 1'b1;
        s_rdata = pdat;
        pend = 1'b0;
      end
      if (s_valid) begin
        int k = 0;
        for (int i = 0; i <= NP; i++) if (s_sel[i]) k = i;
        n_fwd++;
        last_mid = s_mid;
        last_sel = s_sel;
        if (s_write) mem[k][s_addr[5:2]] = s_wdata;
        else pdat = mem[k][s_addr[5:2]];
        pend = 1'b1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int port, input logic [AW-1:0] a, input logic w,
                      input logic [DW-1:0] d, input logic dma,
                      output logic [DW-1:0] rdata, output logic err, output int lat);
    @(negedge clk);
    if (port == 0) begin m_valid = 1; m_addr = a; m_write = w; m_wdata = d; end
    else begin h_valid = 1; h_addr = a; h_write = w; h_wdata = d; h_dma = dma; end
    @(posedge clk);
    @(negedge clk);
    if (port == 0) m_valid = 0; else h_valid = 0;
    lat = 1;
    while (!(port == 0 ? m_rsp_valid : h_rsp_valid) && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    rdata = (port == 0) ? m_rsp_rdata : h_rsp_rdata;
    err   = (port == 0) ? m_rsp_err : h_rsp_err;
  endtask

  logic [DW-1:0] rd;
  logic er;
  int lt;

  task automatic t_reset();
    chk(m_ready && h_ready, "R2 ready after reset", {m_ready, h_ready}, 2'b11);
    chk(!s_valid && !m_rsp_valid && !h_rsp_valid, "R2 quiet after reset", s_valid, 0);
    xfer(0, 16'hF000, 0, 0, 0, rd, er, lt);
    chk(rd == 0 && !er, "R2 lock clear at reset", rd, 0);
    chk(lt == 1, "R2 control latency", lt, 1);
  endtask

  task automatic t_forward();
    int n0 = n_fwd;
    xfer(1, 16'h0010, 1, 32'hA5A5_0001, 0, rd, er, lt);
    chk(!er && n_fwd == n0 + 1, "R9 cpu write forwarded", n_fwd - n0, 1);
    chk(last_mid == 2'd1 && last_sel == 5'b00001, "R9 cpu tag/sel", {last_mid, last_sel}, {2'd1, 5'b00001});
    xfer(1, 16'h0010, 0, 0, 1, rd, er, lt);
    chk(!er && rd == 32'hA5A5_0001, "R9 dma read data", rd, 32'hA5A5_0001);
    chk(last_mid == 2'd2, "R9 dma tag", last_mid, 2);
    xfer(1, 16'h9004, 1, 32'h55, 0, rd, er, lt);
    chk(!er && last_sel == 5'b10000, "R7 open memory for main", last_sel, 5'b10000);
  endtask

  task automatic t_lock();
    int n0;
    xfer(0, 16'hF000, 1, 32'h4, 0, rd, er, lt);
    xfer(0, 16'hF000, 0, 0, 0, rd, er, lt);
    chk(rd == 32'h4, "R2 lock set readback", rd, 4);
    n0 = n_fwd;
    xfer(1, 16'h2004, 0, 0, 0, rd, er, lt);
    chk(er && n_fwd == n0, "R4 locked main blocked", {er, 8'(n_fwd - n0)}, 9'h100);
    chk(lt == LAT && rd == 0, "R5 error latency and data", lt, LAT);
    xfer(1, 16'h2008, 1, 1, 1, rd, er, lt);
    chk(er && lt == LAT, "R4 locked dma blocked", lt, LAT);
    xfer(1, 16'h1004, 1, 32'h77, 0, rd, er, lt);
    chk(!er, "R4 other peripheral open", er, 0);
  endtask

  task automatic t_monitor();
    xfer(0, 16'h200C, 1, 32'hCAFE, 0, rd, er, lt);
    chk(!er && last_mid == 2'd0, "R6 monitor write locked", er, 0);
    xfer(0, 16'h200C, 0, 0, 0, rd, er, lt);
    chk(!er && rd == 32'hCAFE, "R6 monitor read locked", rd, 32'hCAFE);
  endtask

  task automatic t_main_ctrl();
    xfer(1, 16'hF004, 1, 32'hF, 0, rd, er, lt);
    chk(er && lt == LAT, "R1 main release rejected", lt, LAT);
    xfer(1, 16'hF000, 1, 32'h1, 1, rd, er, lt);
    chk(er, "R1 main set rejected", er, 1);
    xfer(0, 16'hF000, 0, 0, 0, rd, er, lt);
    chk(rd == 32'h4, "R1 lock unchanged", rd, 4);
  endtask

  task automatic t_release();
    xfer(0, 16'hF000, 1, 32'h3, 0, rd, er, lt);
    xfer(0, 16'hF004, 1, 32'h6, 0, rd, er, lt);
    xfer(0, 16'hF000, 0, 0, 0, rd, er, lt);
    chk(rd == 32'h1, "R3 selective release", rd, 1);
    xfer(1, 16'h200C, 0, 0, 0, rd, er, lt);
    chk(!er && rd == 32'hCAFE, "R3 released peripheral open", rd, 32'hCAFE);
    xfer(0, 16'hF004, 1, 32'h1, 0, rd, er, lt);
  endtask

  task automatic t_windows();
    int n0 = n_fwd;
    xfer(0, 16'h8100, 1, 32'hBEEF, 0, rd, er, lt);
    chk(!er && n_fwd == n0 + 1, "R7 monitor window write", er, 0);
    xfer(1, 16'h8100, 0, 0, 0, rd, er, lt);
    chk(er && rd == 0 && lt == LAT, "R7 main window0 rejected", rd, 0);
    xfer(1, 16'hA0F0, 1, 1, 1, rd, er, lt);
    chk(er, "R7 main window1 rejected", er, 1);
    xfer(1, 16'h8800, 0, 0, 0, rd, er, lt);
    chk(!er, "R7 main outside window", er, 0);
    xfer(0, 16'h8100, 0, 0, 0, rd, er, lt);
    chk(rd == 32'hBEEF, "R7 window data intact", rd, 32'hBEEF);
  endtask

  task automatic t_unmapped();
    xfer(0, 16'h5000, 0, 0, 0, rd, er, lt);
    chk(er && lt == LAT, "R10 monitor unmapped", lt, LAT);
    xfer(1, 16'hC000, 0, 0, 0, rd, er, lt);
    chk(er && lt == LAT, "R10 main unmapped", lt, LAT);
  endtask

  task automatic t_inflight();
    logic [DW-1:0] r1, r2;
    logic e1, e2;
    int l1, l2, n0;
    n0 = n_fwd;
    fork
      xfer(1, 16'h3008, 1, 32'h1234, 0, r1, e1, l1);
      xfer(0, 16'hF000, 1, 32'h8, 0, r2, e2, l2);
    join
    chk(!e1 && n_fwd == n0 + 1, "R8 in-flight transfer completes", e1, 0);
    xfer(1, 16'h3008, 0, 0, 0, rd, er, lt);
    chk(er, "R8 later request locked", er, 1);
    xfer(0, 16'h3008, 0, 0, 0, rd, er, lt);
    chk(rd == 32'h1234, "R8 data reached slave", rd, 32'h1234);
    xfer(0, 16'hF004, 1, 32'hF, 0, rd, er, lt);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_lock();
    t_monitor();
    t_main_ctrl();
    t_release();
    t_windows();
    t_unmapped();
    t_inflight();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule